// File: doc/BRIEF.md
# Exception and Call Stack Sequencer

This block is the stack-handling part of a small 16-bit processor core. It owns the extended program counter, the extended stack pointer and the condition-code word. The extended program counter is a 4-bit bank extension followed by a 16-bit program counter. The bank extension is not kept in a register of its own: it lives in the low four bits of the condition-code word. Storing the condition-code word on the stack therefore also saves the bank.

Five one-cycle command strobes select a sequence:

- software interrupt
- interrupt return
- short subroutine call
- long call
- subroutine return

Each sequence moves 16-bit words between the registers and memory over a single-port memory interface, at most one access per cycle. Read data comes back on the cycle after the address.

The prefetch pipeline runs ahead of execution, so the sequencer applies fixed address corrections to the return address. All address arithmetic is modulo 2^20, so carries and borrows cross between the 16-bit program counter and its 4-bit extension.

Top module: `exc_stack_seq`

## Requirements
- R1: While reset is asserted at a clock edge, the block becomes idle with busy low and no memory request. pc_o takes rst_pc_i, sp_o takes rst_sp_i, and ccr_o becomes rst_pc_i[19:16] in bits 3:0 with zeros above.
- R2: The software-interrupt strobe first forms P = pc_o + 2. It then writes P[15:0] at address sp_o, and next writes the condition-code word, with bits 3:0 equal to P[19:16], at sp_o - 2. sp_o ends 4 lower.
- R3: After its two writes, a software interrupt reads address 0x0000C. On the following cycle it loads pc_o with bank 0 and the returned word. Busy lasts exactly four cycles.
- R4: The interrupt-return strobe reads the condition-code word C at sp_o + 2 and then the PC word W at sp_o + 4, so sp_o ends 4 higher. pc_o becomes V = {C[3:0], W} - 6, and ccr_o becomes {C[15:4], V[19:16]}.
- R5: The short-call strobe forms P = pc_o - 2 and pushes it exactly as in R2. pc_o then becomes tgt_i (captured with the strobe), and ccr_o bits 3:0 become tgt_i[19:16].
- R6: The long-call strobe behaves as in R5 but pushes pc_o unmodified.
- R7: The subroutine-return strobe pulls as in R4, and pc_o becomes V = {C[3:0], W} - 2. Only ccr_o bits 3:0 change, to V[19:16]; bits 15:4 keep their previous value.
- R8: Every change of program counter and stack pointer is modulo 2^20, with carry and borrow between bit 15 and bit 16.
- R9: busy_o is high from the cycle after an accepted strobe until the sequence ends. Strobes seen while busy are ignored. mem_req_o is high only while busy, mem_we_o only with mem_req_o, and read data is taken only on the cycle after a read address.
- R10: When several strobes arrive together, exactly one is accepted. The order from highest priority is software interrupt, interrupt return, short call, long call, subroutine return.
- R11: While idle with no strobe, pc_o, sp_o and ccr_o hold and no memory request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rst_pc_i | input | 20 | Extended program counter loaded at reset |
| rst_sp_i | input | 20 | Extended stack pointer loaded at reset |
| swi_i | input | 1 | Software-interrupt strobe |
| rti_i | input | 1 | Interrupt-return strobe |
| bsr_i | input | 1 | Short (2-byte) subroutine-call strobe |
| jsr_i | input | 1 | Long (4-byte) call strobe |
| rts_i | input | 1 | Subroutine-return strobe |
| tgt_i | input | 20 | Call target, sampled with a call strobe |
| busy_o | output | 1 | Sequence in progress |
| pc_o | output | 20 | Extended program counter {bank, PC} |
| sp_o | output | 20 | Extended stack pointer |
| ccr_o | output | 16 | Condition-code word, bank in bits 3:0 |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 20 | Byte address of the word access |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid the cycle after a read |

## Verification
The embedded assertions watch the cycle-level rules on every cycle:

- memory traffic appears only while busy;
- a write never occurs without a request;
- every word written moves the stack pointer down by two on the next cycle;
- registers hold while idle with no strobe;
- a captured command cannot change mid-sequence;
- the bank is zero right after a vector load.

Only the bench's scenarios can show the values that travel through memory. These are the stacked words, the pipeline corrections after a round trip, the borrow from the PC into the bank, strobe priority, and a strobe dropped while busy. The bench checks them against an independent reference model that runs on every clock.

// File: rtl/esq_pkg.sv
package esq_pkg;

    localparam int ESQ_PCW = 16;
    localparam int ESQ_XW  = 4;
    localparam int ESQ_CCW = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_PC,
        ST_PUSH_CC,
        ST_VEC_RD,
        ST_VEC_LD,
        ST_PULL_CC,
        ST_PULL_PC,
        ST_PULL_FIN
    } seq_st_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_SWI,
        OP_RTI,
        OP_BSR,
        OP_JSR,
        OP_RTS
    } seq_op_e;

endpackage

// File: rtl/esq_xadd.sv
// Modular adder: W-bit address plus a sign-extended DW-bit offset.
module esq_xadd #(
    parameter int W  = 20,
    parameter int DW = 8
) (
    input  logic [W-1:0]  a_i,
    input  logic [DW-1:0] d_i,
    output logic [W-1:0]  y_o
);
    generate
        if (W > DW) begin : g_ext
            assign y_o = a_i + {{(W-DW){d_i[DW-1]}}, d_i};
        end else begin : g_trunc
            assign y_o = a_i + d_i[W-1:0];
        end
    endgenerate
endmodule

// File: rtl/esq_pick.sv
// Fixed-priority selection among simultaneous command strobes.
module esq_pick (
    input  logic              swi_i,
    input  logic              rti_i,
    input  logic              bsr_i,
    input  logic              jsr_i,
    input  logic              rts_i,
    output esq_pkg::seq_op_e  op_o
);
    import esq_pkg::*;
    always_comb begin
        if (swi_i)      op_o = OP_SWI;
        else if (rti_i) op_o = OP_RTI;
        else if (bsr_i) op_o = OP_BSR;
        else if (jsr_i) op_o = OP_JSR;
        else if (rts_i) op_o = OP_RTS;
        else            op_o = OP_NONE;
    end
endmodule

// File: rtl/exc_stack_seq.sv
module exc_stack_seq #(
    parameter int PCW      = esq_pkg::ESQ_PCW,
    parameter int XW       = esq_pkg::ESQ_XW,
    parameter int CCW      = esq_pkg::ESQ_CCW,
    parameter int VEC_ADDR = 12,
    parameter int SWI_FIX  = 2,
    parameter int RTI_FIX  = 6,
    parameter int CALL_FIX = 2,
    parameter int WSTEP    = 2,
    localparam int AW      = PCW + XW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [AW-1:0]  rst_pc_i,
    input  logic [AW-1:0]  rst_sp_i,
    input  logic           swi_i,
    input  logic           rti_i,
    input  logic           bsr_i,
    input  logic           jsr_i,
    input  logic           rts_i,
    input  logic [AW-1:0]  tgt_i,
    output logic           busy_o,
    output logic [AW-1:0]  pc_o,
    output logic [AW-1:0]  sp_o,
    output logic [CCW-1:0] ccr_o,
    output logic           mem_req_o,
    output logic           mem_we_o,
    output logic [AW-1:0]  mem_addr_o,
    output logic [PCW-1:0] mem_wdata_o,
    input  logic [PCW-1:0] mem_rdata_i
);
    import esq_pkg::*;

    localparam int DW = 8;

    typedef struct packed {
        seq_st_e        st;
        seq_op_e        op;
        logic [PCW-1:0] pc;
        logic [AW-1:0]  sp;
        logic [CCW-1:0] cc;
        logic [AW-1:0]  tgt;
        logic [CCW-1:0] pulled;
    } seq_regs_t;

    seq_regs_t r_q, r_d;
    seq_op_e   op_pick;
    logic [DW-1:0] cmd_delta, sp_delta, pull_delta;
    logic [AW-1:0] cmd_adj, sp_step, pull_adj;
    logic          any_strobe;

    esq_pick u_pick (
        .swi_i(swi_i), .rti_i(rti_i), .bsr_i(bsr_i),
        .jsr_i(jsr_i), .rts_i(rts_i), .op_o(op_pick)
    );

    always_comb begin
        case (op_pick)
            OP_SWI:  cmd_delta = DW'(SWI_FIX);
            OP_BSR:  cmd_delta = DW'(-CALL_FIX);
            default: cmd_delta = '0;
        endcase
        sp_delta   = (r_q.st == ST_PUSH_PC || r_q.st == ST_PUSH_CC) ? DW'(-WSTEP) : DW'(WSTEP);
        pull_delta = (r_q.op == OP_RTI) ? DW'(-RTI_FIX) : DW'(-CALL_FIX);
    end

    esq_xadd #(.W(AW), .DW(DW)) u_cmd_adj (
        .a_i({r_q.cc[XW-1:0], r_q.pc}), .d_i(cmd_delta), .y_o(cmd_adj)
    );
    esq_xadd #(.W(AW), .DW(DW)) u_sp_step (
        .a_i(r_q.sp), .d_i(sp_delta), .y_o(sp_step)
    );
    esq_xadd #(.W(AW), .DW(DW)) u_pull_adj (
        .a_i({r_q.pulled[XW-1:0], mem_rdata_i}), .d_i(pull_delta), .y_o(pull_adj)
    );

    always_comb begin
        r_d         = r_q;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        case (r_q.st)
            ST_IDLE: begin
                if (op_pick != OP_NONE) begin
                    r_d.op  = op_pick;
                    r_d.tgt = tgt_i;
                    if (op_pick == OP_RTI || op_pick == OP_RTS) begin
                        r_d.sp = sp_step;
                        r_d.st = ST_PULL_CC;
                    end else begin
                        r_d.pc          = cmd_adj[PCW-1:0];
                        r_d.cc[XW-1:0]  = cmd_adj[AW-1:PCW];
                        r_d.st          = ST_PUSH_PC;
                    end
                end
            end
            ST_PUSH_PC: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = r_q.sp;
                mem_wdata_o = r_q.pc;
                r_d.sp      = sp_step;
                r_d.st      = ST_PUSH_CC;
            end
            ST_PUSH_CC: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = r_q.sp;
                mem_wdata_o = r_q.cc;
                r_d.sp      = sp_step;
                if (r_q.op == OP_SWI) begin
                    r_d.st = ST_VEC_RD;
                end else begin
                    r_d.pc         = r_q.tgt[PCW-1:0];
                    r_d.cc[XW-1:0] = r_q.tgt[AW-1:PCW];
                    r_d.st         = ST_IDLE;
                end
            end
            ST_VEC_RD: begin
                mem_req_o  = 1'b1;
                mem_addr_o = AW'(VEC_ADDR);
                r_d.st     = ST_VEC_LD;
            end
            ST_VEC_LD: begin
                r_d.pc         = mem_rdata_i;
                r_d.cc[XW-1:0] = '0;
                r_d.st         = ST_IDLE;
            end
            ST_PULL_CC: begin
                mem_req_o  = 1'b1;
                mem_addr_o = r_q.sp;
                r_d.sp     = sp_step;
                r_d.st     = ST_PULL_PC;
            end
            ST_PULL_PC: begin
                mem_req_o  = 1'b1;
                mem_addr_o = r_q.sp;
                r_d.pulled = mem_rdata_i;
                r_d.st     = ST_PULL_FIN;
            end
            ST_PULL_FIN: begin
                r_d.pc = pull_adj[PCW-1:0];
                if (r_q.op == OP_RTI)
                    r_d.cc = {r_q.pulled[CCW-1:XW], pull_adj[AW-1:PCW]};
                else
                    r_d.cc = {r_q.cc[CCW-1:XW], pull_adj[AW-1:PCW]};
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st     <= ST_IDLE;
            r_q.op     <= OP_NONE;
            r_q.pc     <= rst_pc_i[PCW-1:0];
            r_q.sp     <= rst_sp_i;
            r_q.cc     <= {{(CCW-XW){1'b0}}, rst_pc_i[AW-1:PCW]};
            r_q.tgt    <= '0;
            r_q.pulled <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o     = (r_q.st != ST_IDLE);
    assign pc_o       = {r_q.cc[XW-1:0], r_q.pc};
    assign sp_o       = r_q.sp;
    assign ccr_o      = r_q.cc;
    assign any_strobe = swi_i | rti_i | bsr_i | jsr_i | rts_i;

    // R9: memory traffic only inside a sequence
    assert_mem_only_busy_R9: assert property (@(posedge clk) disable iff (rst)
        mem_req_o |-> busy_o);
    // R9: a write is always a request
    assert_we_needs_req_R9: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> mem_req_o);
    // R9: a captured command survives strobes until the sequence ends
    assert_op_held_R9: assert property (@(posedge clk) disable iff (rst)
        (busy_o && any_strobe) |=> $stable(r_q.op));
    // R8: each stored word lowers the stack pointer by one word, modulo 2^20
    assert_push_step_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && mem_we_o) |=> (sp_o == AW'($past(sp_o) - AW'(WSTEP))));
    // R3: vector load leaves bank 0
    assert_vec_bank_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_VEC_LD) |=> (pc_o[AW-1:PCW] == '0));
    // R11: idle with no strobe keeps architectural state
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !any_strobe) |=> ($stable(pc_o) && $stable(sp_o) && $stable(ccr_o)));

endmodule

// File: tb/sim_exc_stack_seq.sv
module sim_exc_stack_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] rst_pc = '0, rst_sp = '0, tgt = '0;
    logic        swi = 0, rti = 0, bsr = 0, jsr = 0, rts = 0;
    logic        busy, mem_req, mem_we;
    logic [19:0] pc, sp, mem_addr;
    logic [15:0] ccr, mem_wdata;
    logic [15:0] mem_rdata = 16'hDEAD;

    always #2 clk = ~clk;

    exc_stack_seq u0 (
        .clk(clk), .rst(rst), .rst_pc_i(rst_pc), .rst_sp_i(rst_sp),
        .swi_i(swi), .rti_i(rti), .bsr_i(bsr), .jsr_i(jsr), .rts_i(rts),
        .tgt_i(tgt), .busy_o(busy), .pc_o(pc), .sp_o(sp), .ccr_o(ccr),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
    );

    // behavioural word memory, one-cycle read latency, garbage when not read
    logic [15:0] mem [bit [19:0]];
    function automatic logic [15:0] rd(input bit [19:0] a);
        return mem.exists(a) ? mem[a] : 16'h0000;
    endfunction
    always @(posedge clk) begin
        if (mem_req && !mem_we) mem_rdata <= rd(mem_addr);
        else                    mem_rdata <= 16'hDEAD;
        if (mem_req && mem_we)  mem[mem_addr] = mem_wdata;
    end

    typedef struct { bit req; bit we; bit [19:0] addr; bit [15:0] wd; } bus_t;
    bus_t        q[$];
    bit [19:0]   m_pc, m_sp;
    bit [15:0]   m_cc;
    int          n_cmp = 0, n_bad = 0;
    bit          done = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic bus_t mk(bit r, bit w, bit [19:0] a, bit [15:0] d);
        bus_t b; b.req = r; b.we = w; b.addr = a; b.wd = d; return b;
    endfunction

    // reference model: builds the per-cycle bus expectation and final state
    task automatic accept(input bit [4:0] s, input bit [19:0] t);
        bit [19:0] adj, v;
        bit [15:0] c, w;
        if (s[4] || s[2] || s[1]) begin
            adj = s[4] ? m_pc + 20'd2 : (s[2] ? m_pc - 20'd2 : m_pc);
            q.push_back(mk(1, 1, m_sp, adj[15:0]));
            q.push_back(mk(1, 1, m_sp - 20'd2, {m_cc[15:4], adj[19:16]}));
            m_sp = m_sp - 20'd4;
            if (s[4]) begin
                q.push_back(mk(1, 0, 20'h0000C, 16'h0));
                q.push_back(mk(0, 0, 20'h0, 16'h0));
                m_pc = {4'h0, rd(20'h0000C)};
                m_cc = {m_cc[15:4], 4'h0};
            end else begin
                m_pc = t;
                m_cc = {m_cc[15:4], t[19:16]};
            end
        end else begin
            c = rd(m_sp + 20'd2);
            w = rd(m_sp + 20'd4);
            q.push_back(mk(1, 0, m_sp + 20'd2, 16'h0));
            q.push_back(mk(1, 0, m_sp + 20'd4, 16'h0));
            q.push_back(mk(0, 0, 20'h0, 16'h0));
            v = {c[3:0], w} - (s[3] ? 20'd6 : 20'd2);
            m_cc = s[3] ? {c[15:4], v[19:16]} : {m_cc[15:4], v[19:16]};
            m_pc = v;
            m_sp = m_sp + 20'd4;
        end
    endtask

    task automatic compare(input string tag);
        chk(busy === (q.size() != 0), tag, "busy", {31'b0, busy}, {31'b0, q.size() != 0});
        if (q.size() != 0) begin
            chk(mem_req === q[0].req, tag, "mem_req", {31'b0, mem_req}, {31'b0, q[0].req});
            chk(mem_we === q[0].we, tag, "mem_we", {31'b0, mem_we}, {31'b0, q[0].we});
            if (q[0].req)
                chk(mem_addr === q[0].addr, tag, "mem_addr", {12'b0, mem_addr}, {12'b0, q[0].addr});
            if (q[0].we)
                chk(mem_wdata === q[0].wd, tag, "mem_wdata", {16'b0, mem_wdata}, {16'b0, q[0].wd});
        end else begin
            chk(mem_req === 1'b0, tag, "mem_req idle", {31'b0, mem_req}, 32'd0);
            chk(pc === m_pc, tag, "pc", {12'b0, pc}, {12'b0, m_pc});
            chk(sp === m_sp, tag, "sp", {12'b0, sp}, {12'b0, m_sp});
            chk(ccr === m_cc, tag, "ccr", {16'b0, ccr}, {16'b0, m_cc});
        end
    endtask

    // strobes order: {swi, rti, bsr, jsr, rts}
    task automatic tick(input bit [4:0] s, input bit [19:0] t, input string tag);
        {swi, rti, bsr, jsr, rts} = s;
        tgt = t;
        @(posedge clk); #1;
        if (q.size() != 0) void'(q.pop_front());
        else if (s != 0) begin
            if (s[4])      accept(5'b10000, t);
            else if (s[3]) accept(5'b01000, t);
            else if (s[2]) accept(5'b00100, t);
            else if (s[1]) accept(5'b00010, t);
            else           accept(5'b00001, t);
        end
        {swi, rti, bsr, jsr, rts} = '0;
        @(negedge clk);
        compare(tag);
    endtask

    task automatic run_to_idle(input string tag);
        while (q.size() != 0) tick(5'b0, 20'h0, tag);
    endtask

    task automatic do_reset(input bit [19:0] p, input bit [19:0] s);
        rst = 1; rst_pc = p; rst_sp = s;
        @(posedge clk); #1;
        q.delete();
        m_pc = p; m_sp = s; m_cc = {12'h0, p[19:16]};
        @(negedge clk);
        compare("R1");
        rst = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        mem[20'h0000C] = 16'h4400;
        @(negedge clk);
        do_reset(20'h31234, 20'h08000);                  // R1 reset state
        tick(5'b0, 20'h0, "R11");                        // R11 idle holds
        tick(5'b0, 20'h0, "R11");

        tick(5'b10000, 20'h0, "R2");                     // R2 software interrupt stacking
        run_to_idle("R3");                               // R3 vector fetch, bank cleared
        tick(5'b01000, 20'h0, "R4");                     // R4 interrupt return, -6
        run_to_idle("R4");

        tick(5'b00100, 20'h5A000, "R5");                 // R5 short call, -2 on stacked value
        run_to_idle("R5");
        tick(5'b00001, 20'h0, "R7");                     // R7 return, -2, flags kept
        run_to_idle("R7");
        tick(5'b00010, 20'h7B0F0, "R6");                 // R6 long call, no correction
        run_to_idle("R6");
        tick(5'b00001, 20'h0, "R7");
        run_to_idle("R7");

        // R9: strobes during a sequence are dropped
        tick(5'b10000, 20'h0, "R9");
        tick(5'b01000, 20'h0, "R9");
        tick(5'b00100, 20'h12345, "R9");
        run_to_idle("R9");
        tick(5'b0, 20'h0, "R9");

        // R10: priority among simultaneous strobes
        tick(5'b00101, 20'h23456, "R10");                // short call beats return
        run_to_idle("R10");
        tick(5'b11111, 20'h34567, "R10");                // software interrupt wins
        run_to_idle("R10");
        tick(5'b01011, 20'h0, "R10");                    // interrupt return wins
        run_to_idle("R10");

        // R8: carry out of PC into bank and stack wrap below zero
        do_reset(20'hFFFFE, 20'h00002);
        tick(5'b10000, 20'h0, "R8");
        run_to_idle("R8");
        tick(5'b01000, 20'h0, "R8");
        run_to_idle("R8");

        // R4/R8: borrow from PC into bank, full flag restore
        do_reset(20'h10000, 20'h09000);
        mem[20'h09002] = 16'hA5F3;
        mem[20'h09004] = 16'h0004;
        tick(5'b01000, 20'h0, "R4");
        run_to_idle("R8");
        tick(5'b0, 20'h0, "R11");

        // R7: return keeps flag bits, borrow through bank
        mem[20'h09006] = 16'h3C91;
        mem[20'h09008] = 16'h0000;
        tick(5'b00001, 20'h0, "R7");
        run_to_idle("R7");
        tick(5'b0, 20'h0, "R11");

        finish_run();
    end

endmodule